// File: doc/BRIEF.md
# Write-Once Timing Tick Divider

This block turns a fast oscillator clock into a slow time-base strobe of roughly 1 MHz. A non-volatile memory controller uses that strobe to time its program and erase steps. Software sets the division ratio through a small register port. The strobe is a one-cycle enable on the oscillator clock, not a second clock, so everything downstream stays in one clock domain.

The ratio can be set exactly once after each reset. The first accepted write also raises a read-only flag that reports the ratio is in place, and a downstream controller can refuse work until that flag is set. Writes are refused while a memory command is running. The one exception is while the reset sequence is active: writes are then accepted even though a command is still flagged as running. A refused write does not use up the single permitted write.

Top module: `nvm_tick_divider`

## Requirements
- R1: The control word sits at offset 0x0 and reads as {loaded flag in bit 7, ratio in bits 6..0}. A read of any other offset returns 0x00. Read data is combinational on the address.
- R2: After reset the control word reads 0x00, the loaded flag is 0 and no tick is produced.
- R3: The first accepted write, at offset 0x0, stores wdata[6:0] as the ratio. The flag reads 1 from the next cycle and stays 1 until reset.
- R4: Once the flag is 1, every further write leaves the control word unchanged.
- R5: A write made while cmd_busy=1 and seq_active=0 is refused. The flag stays 0, and a later legal write is still accepted.
- R6: A write made while cmd_busy=1 and seq_active=1 is accepted.
- R7: Number the cycles from 0, starting with the first cycle in which the flag reads 1, and let the ratio be N. Then tick_en is high exactly in the cycles whose number modulo N+1 equals N, which gives one tick every N+1 cycles. A rejected write does not restart this count.
- R8: tick_en stays 0 while the flag is 0.
- R9: wdata bit 7 has no effect: only an accepted write sets the flag, whatever the value of bit 7. Writes to a nonzero offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| cmd_busy | input | 1 | High while a memory command is running |
| seq_active | input | 1 | High while the reset sequence runs |
| tick_en | output | 1 | One-cycle time-base strobe |
| div_loaded | output | 1 | Ratio has been set since reset |

## Verification
Two functions can land in the same cycle.

The first pair is the busy refusal and the reset-sequence exception. The bench provokes it by raising cmd_busy and seq_active together during a write. It also makes the same write with only cmd_busy raised, and judges that only the first attempt takes.

The second pair is a write and a tick. The bench puts a late write on a cycle where the strobe fires. It then checks that the strobe spacing and the stored word are untouched. A behavioural model is compared on every clock, and it counts cycles since the load, not counter states.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;
  localparam int unsigned DIV_W  = 7;
  localparam int unsigned WORD_W = DIV_W + 1;

  // Next counter value: wraps to zero on the terminal count.
  function automatic logic [DIV_W-1:0] f_next_count(input logic [DIV_W-1:0] cnt,
                                                    input logic [DIV_W-1:0] ratio);
    if (cnt == ratio) return '0;
    return cnt + 1'b1;
  endfunction

  // Busy rule with the reset-sequence exception.
  function automatic logic f_write_allowed(input logic busy, input logic seq);
    return (!busy) || seq;
  endfunction

  // Read word layout: flag on top, ratio below.
  function automatic logic [WORD_W-1:0] f_read_word(input logic loaded,
                                                    input logic [DIV_W-1:0] ratio);
    return {loaded, ratio};
  endfunction
endpackage

// File: rtl/nvm_tick_cfg.sv
module nvm_tick_cfg
  import nvm_tick_pkg::*;
#(
  parameter int unsigned RW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [RW-1:0] wr_ratio,
  input  logic          cmd_busy,
  input  logic          seq_active,
  output logic          accept,
  output logic          loaded,
  output logic [RW-1:0] ratio
);
  logic allowed;

  always_comb begin
    allowed = f_write_allowed(cmd_busy, seq_active);
    accept  = wr_hit && allowed && !loaded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      ratio  <= '0;
    end else if (accept) begin
      loaded <= 1'b1;
      ratio  <= wr_ratio;
    end
  end

  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> (loaded && $stable(ratio)));
  p_busy_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && cmd_busy && !seq_active && !loaded) |=> !loaded);
  p_seq_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && seq_active && !loaded) |=> (loaded && ratio == $past(wr_ratio)));
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(wr_hit));
endmodule

// File: rtl/nvm_tick_counter.sv
module nvm_tick_counter
  import nvm_tick_pkg::*;
#(
  parameter int unsigned RW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [RW-1:0] ratio,
  output logic          tick,
  output logic [RW-1:0] count
);
  logic terminal;

  always_comb begin
    terminal = (count == ratio);
    tick     = run && terminal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (!run)    count <= '0;
    else              count <= f_next_count(count, ratio);
  end

  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio != '0 && !restart) |=> !tick);
  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count <= ratio));
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));
endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
  import nvm_tick_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CTRL_OFFS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_busy,
  input  logic              seq_active,
  output logic              tick_en,
  output logic              div_loaded
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(CTRL_OFFS);

  logic             sel_ctrl;
  logic             wr_hit;
  logic             load_evt;
  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt_q;

  always_comb begin
    sel_ctrl = (reg_addr == OFFS);
    wr_hit   = reg_we && sel_ctrl;
  end

  nvm_tick_cfg #(.RW(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wr_ratio  (reg_wdata[DIV_W-1:0]),
    .cmd_busy  (cmd_busy),
    .seq_active(seq_active),
    .accept    (load_evt),
    .loaded    (div_loaded),
    .ratio     (ratio_q)
  );

  nvm_tick_counter #(.RW(DIV_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (div_loaded),
    .restart(load_evt),
    .ratio  (ratio_q),
    .tick   (tick_en),
    .count  (cnt_q)
  );

  always_comb begin
    reg_rdata = sel_ctrl ? f_read_word(div_loaded, ratio_q) : '0;
  end

  p_bit7_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt) |=> (reg_rdata[7] || !sel_ctrl));
  p_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel_ctrl && !div_loaded) |=> !div_loaded);
endmodule

// File: tb/test_nvm_tick_divider.sv
module test_nvm_tick_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmd_busy = 1'b0;
  logic       seq_active = 1'b0;
  logic       tick_en;
  logic       div_loaded;

  int checks = 0;
  int errors = 0;

  // behavioural reference
  int m_loaded = 0;
  int m_ratio = 0;
  int m_since = 0;

  always #10 clk = ~clk;

  nvm_tick_divider i_nvm_tick_divider (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_busy(cmd_busy),
    .seq_active(seq_active), .tick_en(tick_en), .div_loaded(div_loaded)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded <= 0; m_ratio <= 0; m_since <= 0;
    end else if (reg_we && reg_addr == 0 && m_loaded == 0 &&
                 (cmd_busy == 1'b0 || seq_active == 1'b1)) begin
      m_loaded <= 1; m_ratio <= reg_wdata % 128; m_since <= 0;
    end else if (m_loaded == 1) begin
      m_since <= m_since + 1;
    end
  end

  always @(negedge clk) begin
    int exp_tick;
    int exp_rd;
    exp_tick = (m_loaded == 1 && (m_since % (m_ratio + 1)) == m_ratio) ? 1 : 0;
    exp_rd   = (reg_addr == 0) ? (m_loaded * 128 + m_ratio) : 0;
    check("R7/R8 tick", int'(tick_en), exp_tick);
    check("R3 flag", int'(div_loaded), m_loaded);
    check("R1 rdata", int'(reg_rdata), exp_rd);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step(1);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_busy = 1'b0; seq_active = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick_en) c++;
    end
    #15;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    check("R2 reset word", int'(reg_rdata), 0);
    check("R2 reset flag", int'(div_loaded), 0);
    #15;
    count_ticks(10, c);
    check("R8 no tick unloaded", c, 0);

    wr(4'h1, 8'h05);
    step(1);
    @(negedge clk); check("R9 stray offset", int'(div_loaded), 0); #15;
    reg_addr = 4'h3;
    @(negedge clk); check("R1 other offset", int'(reg_rdata), 0); #15;
    reg_addr = 4'h0;

    cmd_busy = 1'b1;
    wr(4'h0, 8'h03);
    step(1);
    @(negedge clk); check("R5 busy refused", int'(div_loaded), 0); #15;

    seq_active = 1'b1;
    wr(4'h0, 8'h83);
    seq_active = 1'b0; cmd_busy = 1'b0;
    @(negedge clk); check("R6 seq accept", int'(reg_rdata), 8'h83); #15;
    count_ticks(16, c);
    check("R7 period 4", c, 4);

    // write landing on a tick cycle must not restart or change anything
    while (tick_en !== 1'b1) begin @(negedge clk); end
    #5;
    wr(4'h0, 8'h10);
    @(negedge clk); check("R4 locked", int'(reg_rdata), 8'h83); #15;
    count_ticks(12, c);
    check("R7 period after late write", c, 3);

    do_reset();
    wr(4'h0, 8'h80);
    @(negedge clk); check("R9 bit7 ignored", int'(reg_rdata), 8'h80); #15;
    count_ticks(8, c);
    check("R7 ratio zero", c, 8);
    wr(4'h0, 8'h7F);
    @(negedge clk); check("R4 second write", int'(reg_rdata), 8'h80); #15;

    do_reset();
    wr(4'h0, 8'h7F);
    count_ticks(256, c);
    check("R7 max ratio", c, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule